// File: doc/BRIEF.md
# Receive Frame Buffer with Interrupt Logic

This block holds one received radio frame so that a host can read it over a byte-wide register bus. A frame port delivers a length byte, then payload bytes, then a trailer strobe that carries a link-quality byte and a signal-strength byte. The block packs these into a 144-byte buffer. The length byte goes at offset 0 and the payload follows it. The two quality bytes sit directly after the payload. The length counts the payload and its 2-byte checksum. It does not count the length byte itself.

When a frame is fully stored, the block sets a receive flag in an interrupt status register. A separate strobe from the transmit side sets a transmit-done flag. A mask register gates both flags onto an active-low interrupt pin. The host clears all pending flags with a single read of the status register.

A lockout bit in a control register freezes the buffer against incoming frames. The host sets it while it reads a frame out, so that a new frame cannot overwrite the one being read.

Top module: `rxfb_top`

## Requirements
- R1: After reset the status register reads 0x00, the mask register reads 0x09, the control register reads 0x00, buffer offset 0 reads 0x00, and irq_no is high.
- R2: A frame started with length L (L at most 141) stores L at buffer offset 0. Its payload bytes are stored in arrival order at offsets 1 to L.
- R3: The link-quality byte is stored at offset L+1 and the signal-strength byte at offset L+2. Both are stored without a payload byte strobe.
- R4: Status bit 3 is set once the signal-strength byte of a frame has been stored. A one-cycle pulse on tx_done_i sets status bit 0.
- R5: A frame length above 141 is stored as 141 and sets status bit 7. Payload bytes beyond 141 are dropped, and the trailer goes to offsets 142 and 143.
- R6: A read of the status register (address 0x90) returns the flags and clears all of them. A flag that is set in the same cycle as the read survives and shows on the next read.
- R7: Mask register bit 0 gates the transmit flag and bit 3 gates the receive flag, where a 1 disables the source. irq_no is low exactly when some flag is set and its mask bit is clear.
- R8: Control register bit 2 is the lockout. A frame started while lockout is set leaves the buffer unchanged and sets no flag. Setting lockout in the middle of a frame discards the rest of that frame, and no receive flag is raised.
- R9: The mask is at address 0x91 and the control register at 0x92. Each reads back only its defined bits. Bus writes to buffer addresses 0x00 to 0x8F are ignored. Read data appears on reg_rdata_o in the cycle after reg_re_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frm_start_i | input | 1 | Frame start strobe; length is taken from frm_len_i |
| frm_len_i | input | 8 | Frame length: payload plus checksum |
| frm_valid_i | input | 1 | Payload byte strobe |
| frm_data_i | input | 8 | Payload byte |
| frm_end_i | input | 1 | Trailer strobe |
| frm_lqi_i | input | 8 | Link-quality byte, taken with the trailer strobe |
| frm_rssi_i | input | 8 | Signal-strength byte, taken with the trailer strobe |
| tx_done_i | input | 1 | Transmit-complete pulse |
| reg_we_i | input | 1 | Register bus write strobe |
| reg_re_i | input | 1 | Register bus read strobe |
| reg_addr_i | input | 8 | Register bus byte address |
| reg_wdata_i | input | 8 | Register bus write data |
| reg_rdata_o | output | 8 | Registered read data |
| irq_no | output | 1 | Interrupt request, active low |

## Verification
The bench sends one frame for every length from 0 to 145 and reads back every stored byte. This separates correct offset arithmetic from off-by-one placement of the trailer, and it exercises the clamp at lengths 142 to 145. For each of the four mask settings, every combination of pending transmit and receive flags is driven. This shows whether each mask bit gates only its own source. A status read is issued in the same cycle as a transmit pulse to tell "set wins" apart from "clear wins". Frames are also sent with lockout set before the start and with lockout set partway through the payload. In both cases the buffer is compared against a shadow copy to prove it was left intact.

// File: rtl/rxfb_pkg.sv
package rxfb_pkg;
  localparam int unsigned STAT_TX  = 0;
  localparam int unsigned STAT_RX  = 3;
  localparam int unsigned STAT_OVF = 7;
  localparam int unsigned CTRL_LOCK = 2;

  typedef enum logic [1:0] {
    FILL_IDLE,
    FILL_PAY,
    FILL_TRAIL
  } fill_st_e;
endpackage

// File: rtl/rxfb_store.sv
module rxfb_store #(
  parameter int unsigned DEPTH = 144,
  parameter int unsigned DW    = 8,
  parameter int unsigned AW    = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_cell
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mem_q[g] <= '0;
      else if (we_i && (waddr_i == AW'(g))) mem_q[g] <= wdata_i;
    end
  end

  assign rdata_o = (raddr_i < AW'(DEPTH)) ? mem_q[raddr_i] : '0;
endmodule

// File: rtl/rxfb_fill.sv
module rxfb_fill
  import rxfb_pkg::*;
#(
  parameter int unsigned DW      = 8,
  parameter int unsigned AW      = 8,
  parameter int unsigned MAX_LEN = 141
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          lock_i,
  input  logic          start_i,
  input  logic [DW-1:0] len_i,
  input  logic          valid_i,
  input  logic [DW-1:0] data_i,
  input  logic          end_i,
  input  logic [DW-1:0] lqi_i,
  input  logic [DW-1:0] rssi_i,
  output logic          we_o,
  output logic [AW-1:0] waddr_o,
  output logic [DW-1:0] wdata_o,
  output logic          done_o,
  output logic          ovf_o
);
  localparam logic [DW-1:0] MAX_B = DW'(MAX_LEN);

  fill_st_e      st_q, st_d;
  logic [AW-1:0] lim_q, lim_d, cnt_q, cnt_d;
  logic [DW-1:0] rssi_q, rssi_d;
  logic [DW-1:0] len_clamp;

  assign len_clamp = (len_i > MAX_B) ? MAX_B : len_i;

  always_comb begin
    st_d    = st_q;
    lim_d   = lim_q;
    cnt_d   = cnt_q;
    rssi_d  = rssi_q;
    we_o    = 1'b0;
    waddr_o = '0;
    wdata_o = '0;
    done_o  = 1'b0;
    ovf_o   = 1'b0;
    if (lock_i) begin
      st_d = FILL_IDLE;            // lockout abandons any frame in flight
    end else if (start_i) begin
      we_o    = 1'b1;
      wdata_o = len_clamp;
      ovf_o   = (len_i > MAX_B);
      lim_d   = AW'(len_clamp);
      cnt_d   = '0;
      st_d    = FILL_PAY;
    end else begin
      unique case (st_q)
        FILL_PAY: begin
          if (end_i) begin
            we_o    = 1'b1;
            waddr_o = lim_q + AW'(1);
            wdata_o = lqi_i;
            rssi_d  = rssi_i;
            st_d    = FILL_TRAIL;
          end else if (valid_i && (cnt_q < lim_q)) begin
            we_o    = 1'b1;
            waddr_o = cnt_q + AW'(1);
            wdata_o = data_i;
            cnt_d   = cnt_q + AW'(1);
          end
        end
        FILL_TRAIL: begin
          we_o    = 1'b1;
          waddr_o = lim_q + AW'(2);
          wdata_o = rssi_q;
          done_o  = 1'b1;
          st_d    = FILL_IDLE;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= FILL_IDLE;
      lim_q  <= '0;
      cnt_q  <= '0;
      rssi_q <= '0;
    end else begin
      st_q   <= st_d;
      lim_q  <= lim_d;
      cnt_q  <= cnt_d;
      rssi_q <= rssi_d;
    end
  end
endmodule

// File: rtl/rxfb_irq.sv
module rxfb_irq #(
  parameter int unsigned   DW      = 8,
  parameter logic [DW-1:0] SRC_MSK = 8'h09
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] set_i,
  input  logic          clr_i,
  input  logic          mask_we_i,
  input  logic [DW-1:0] mask_wdata_i,
  output logic [DW-1:0] stat_o,
  output logic [DW-1:0] mask_o,
  output logic          irq_no
);
  logic [DW-1:0] stat_q, mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= '0;
      mask_q <= SRC_MSK;
    end else begin
      stat_q <= (clr_i ? '0 : stat_q) | set_i;  // new events outlive the clear
      if (mask_we_i) mask_q <= mask_wdata_i & SRC_MSK;
    end
  end

  assign stat_o = stat_q;
  assign mask_o = mask_q;
  assign irq_no = ~|(stat_q & ~mask_q & SRC_MSK);
endmodule

// File: rtl/rxfb_top.sv
module rxfb_top
  import rxfb_pkg::*;
#(
  parameter int unsigned DEPTH = 144,
  parameter int unsigned DW    = 8,
  parameter int unsigned AW    = $clog2(DEPTH + 3)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          frm_start_i,
  input  logic [DW-1:0] frm_len_i,
  input  logic          frm_valid_i,
  input  logic [DW-1:0] frm_data_i,
  input  logic          frm_end_i,
  input  logic [DW-1:0] frm_lqi_i,
  input  logic [DW-1:0] frm_rssi_i,
  input  logic          tx_done_i,
  input  logic          reg_we_i,
  input  logic          reg_re_i,
  input  logic [AW-1:0] reg_addr_i,
  input  logic [DW-1:0] reg_wdata_i,
  output logic [DW-1:0] reg_rdata_o,
  output logic          irq_no
);
  localparam int unsigned   MAX_LEN   = DEPTH - 3;
  localparam logic [AW-1:0] ADDR_STAT = AW'(DEPTH);
  localparam logic [AW-1:0] ADDR_MASK = AW'(DEPTH + 1);
  localparam logic [AW-1:0] ADDR_CTRL = AW'(DEPTH + 2);
  localparam logic [DW-1:0] SRC_MSK   = DW'((1 << STAT_TX) | (1 << STAT_RX));

  logic          lock_q;
  logic          fill_we, fill_done, fill_ovf;
  logic [AW-1:0] fill_addr;
  logic [DW-1:0] fill_data, buf_rdata, stat_q, mask_q, set_vec, rd_mux, rdata_q;
  logic          rd_stat;

  rxfb_fill #(.DW(DW), .AW(AW), .MAX_LEN(MAX_LEN)) u_fill (
    .clk_i, .rst_ni,
    .lock_i  (lock_q),
    .start_i (frm_start_i),
    .len_i   (frm_len_i),
    .valid_i (frm_valid_i),
    .data_i  (frm_data_i),
    .end_i   (frm_end_i),
    .lqi_i   (frm_lqi_i),
    .rssi_i  (frm_rssi_i),
    .we_o    (fill_we),
    .waddr_o (fill_addr),
    .wdata_o (fill_data),
    .done_o  (fill_done),
    .ovf_o   (fill_ovf)
  );

  rxfb_store #(.DEPTH(DEPTH), .DW(DW), .AW(AW)) u_store (
    .clk_i, .rst_ni,
    .we_i    (fill_we),
    .waddr_i (fill_addr),
    .wdata_i (fill_data),
    .raddr_i (reg_addr_i),
    .rdata_o (buf_rdata)
  );

  always_comb begin
    set_vec           = '0;
    set_vec[STAT_TX]  = tx_done_i;
    set_vec[STAT_RX]  = fill_done;
    set_vec[STAT_OVF] = fill_ovf;
  end

  assign rd_stat = reg_re_i && (reg_addr_i == ADDR_STAT);

  rxfb_irq #(.DW(DW), .SRC_MSK(SRC_MSK)) u_irq (
    .clk_i, .rst_ni,
    .set_i        (set_vec),
    .clr_i        (rd_stat),
    .mask_we_i    (reg_we_i && (reg_addr_i == ADDR_MASK)),
    .mask_wdata_i (reg_wdata_i),
    .stat_o       (stat_q),
    .mask_o       (mask_q),
    .irq_no       (irq_no)
  );

  always_comb begin
    if (reg_addr_i < ADDR_STAT)       rd_mux = buf_rdata;
    else if (reg_addr_i == ADDR_STAT) rd_mux = stat_q;
    else if (reg_addr_i == ADDR_MASK) rd_mux = mask_q;
    else if (reg_addr_i == ADDR_CTRL) rd_mux = DW'(lock_q) << CTRL_LOCK;
    else                              rd_mux = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_q  <= 1'b0;
      rdata_q <= '0;
    end else begin
      if (reg_we_i && (reg_addr_i == ADDR_CTRL)) lock_q <= reg_wdata_i[CTRL_LOCK];
      if (reg_re_i) rdata_q <= rd_mux;
    end
  end

  assign reg_rdata_o = rdata_q;
endmodule

// File: rtl/rxfb_checker.sv
module rxfb_checker #(
  parameter int unsigned DEPTH = 144,
  parameter int unsigned DW    = 8,
  parameter int unsigned AW    = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          tx_done_i,
  input logic          frm_start_i,
  input logic [DW-1:0] frm_len_i,
  input logic          reg_re_i,
  input logic          reg_we_i,
  input logic [AW-1:0] reg_addr_i,
  input logic [DW-1:0] reg_rdata_o,
  input logic          irq_no,
  input logic [DW-1:0] stat_q,
  input logic [DW-1:0] mask_q,
  input logic          lock_q,
  input logic          fill_we,
  input logic          fill_done,
  input logic          fill_ovf
);
  localparam logic [DW-1:0] MAX_B     = DW'(DEPTH - 3);
  localparam logic [AW-1:0] ADDR_STAT = AW'(DEPTH);

  assert_len_clamped_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_re_i && (reg_addr_i == '0) |=> reg_rdata_o <= MAX_B);

  assert_ovf_flag_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frm_start_i && !lock_q && (frm_len_i > MAX_B) |=> stat_q[7]);

  assert_lock_freeze_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_q |-> !fill_we);

  assert_read_clears_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_re_i && (reg_addr_i == ADDR_STAT) && !tx_done_i && !fill_done && !fill_ovf
    |=> stat_q == '0);

  assert_rx_flag_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_done |=> stat_q[3]);

  assert_tx_irq_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_done_i && !mask_q[0] && !reg_we_i |=> !irq_no);

  assert_quiet_pin_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_q == '0) |-> irq_no);
endmodule

bind rxfb_top rxfb_checker #(.DEPTH(DEPTH), .DW(DW), .AW(AW)) chk_i (
  .clk_i, .rst_ni, .tx_done_i, .frm_start_i, .frm_len_i, .reg_re_i, .reg_we_i,
  .reg_addr_i, .reg_rdata_o, .irq_no, .stat_q, .mask_q, .lock_q,
  .fill_we, .fill_done, .fill_ovf
);

// File: tb/rxfb_top_tb_top.sv
module rxfb_top_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       frm_start_i = 1'b0, frm_valid_i = 1'b0, frm_end_i = 1'b0, tx_done_i = 1'b0;
  logic [7:0] frm_len_i = '0, frm_data_i = '0, frm_lqi_i = '0, frm_rssi_i = '0;
  logic       reg_we_i = 1'b0, reg_re_i = 1'b0;
  logic [7:0] reg_addr_i = '0, reg_wdata_i = '0;
  logic [7:0] reg_rdata_o;
  logic       irq_no;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;
  logic [7:0] shadow [144];

  localparam logic [7:0] A_STAT = 8'h90, A_MASK = 8'h91, A_CTRL = 8'h92;

  always #10 clk_i = ~clk_i;

  rxfb_top dut_i (.*);

  function automatic logic [7:0] pay(int len, int i);
    return 8'(len * 7 + i * 13 + 1);
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%02h exp=%02h", tag, act, exp);
    end
  endtask

  task automatic reg_write(logic [7:0] a, logic [7:0] d);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic reg_read(logic [7:0] a, output logic [7:0] d);
    reg_re_i = 1'b1; reg_addr_i = a;
    @(negedge clk_i);
    reg_re_i = 1'b0;
    d = reg_rdata_o;
  endtask

  task automatic send_frame(int len, bit upd);
    int lim = (len > 141) ? 141 : len;
    frm_start_i = 1'b1; frm_len_i = 8'(len);
    @(negedge clk_i);
    frm_start_i = 1'b0;
    for (int i = 0; i < len; i++) begin
      frm_valid_i = 1'b1; frm_data_i = pay(len, i);
      @(negedge clk_i);
    end
    frm_valid_i = 1'b0;
    frm_end_i = 1'b1; frm_lqi_i = 8'(len) ^ 8'h5A; frm_rssi_i = 8'(255 - len);
    @(negedge clk_i);
    frm_end_i = 1'b0;
    @(negedge clk_i);
    if (upd) begin
      shadow[0] = 8'(lim);
      for (int i = 0; i < lim; i++) shadow[1 + i] = pay(len, i);
      shadow[lim + 1] = 8'(len) ^ 8'h5A;
      shadow[lim + 2] = 8'(255 - len);
    end
  endtask

  task automatic check_buf(string tag, int upto);
    logic [7:0] d;
    for (int j = 0; j <= upto; j++) begin
      reg_read(8'(j), d);
      chk(tag, d, shadow[j]);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++; n_bad++;
    $display("FAIL watchdog act=hung exp=done");
    finish_run();
  end

  initial begin
    logic [7:0] d;
    for (int j = 0; j < 144; j++) shadow[j] = 8'h00;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 reset state
    chk("R1 irq_no", {7'b0, irq_no}, 8'h01);
    reg_read(A_STAT, d); chk("R1 status", d, 8'h00);
    reg_read(A_MASK, d); chk("R1 mask", d, 8'h09);
    reg_read(A_CTRL, d); chk("R1 ctrl", d, 8'h00);
    reg_read(8'h00, d);  chk("R1 buf0", d, 8'h00);

    // R2 R3 R5 R4: sweep every length including clamp region
    for (int len = 0; len <= 145; len++) begin
      int lim = (len > 141) ? 141 : len;
      send_frame(len, 1'b1);
      reg_read(A_STAT, d);
      chk("R4/R5 status after frame", d, (len > 141) ? 8'h88 : 8'h08);
      check_buf(len > 141 ? "R5 clamped layout" : "R2/R3 layout", lim + 2);
    end

    // R7 R4 R6: mask sweep over pending flag combinations
    for (int m = 0; m < 4; m++) begin
      reg_write(A_MASK, {4'b0, m[1], 2'b0, m[0]});
      for (int s = 0; s < 4; s++) begin
        if (s[0]) begin
          tx_done_i = 1'b1; @(negedge clk_i); tx_done_i = 1'b0;
        end
        if (s[1]) send_frame(2, 1'b1);
        chk("R7 irq_no", {7'b0, irq_no},
            {7'b0, !((s[0] && !m[0]) || (s[1] && !m[1]))});
        reg_read(A_STAT, d);
        chk("R6/R4 status", d, {4'b0, s[1], 2'b0, s[0]});
        chk("R6 irq_no after clear", {7'b0, irq_no}, 8'h01);
      end
    end
    reg_write(A_MASK, 8'h00);

    // R6: set in the same cycle as the clearing read survives
    tx_done_i = 1'b1; reg_re_i = 1'b1; reg_addr_i = A_STAT;
    @(negedge clk_i);
    tx_done_i = 1'b0; reg_re_i = 1'b0;
    chk("R6 race read", reg_rdata_o, 8'h00);
    chk("R7 irq low on pending tx", {7'b0, irq_no}, 8'h00);
    reg_read(A_STAT, d); chk("R6 race survivor", d, 8'h01);

    // R9 register readback of defined bits
    reg_write(A_MASK, 8'hFF); reg_read(A_MASK, d); chk("R9 mask bits", d, 8'h09);
    reg_write(A_MASK, 8'h00); reg_read(A_MASK, d); chk("R9 mask clear", d, 8'h00);
    reg_write(A_CTRL, 8'hFF); reg_read(A_CTRL, d); chk("R9 ctrl bits", d, 8'h04);

    // R8: frame while locked leaves buffer and flags alone
    send_frame(6, 1'b0);
    reg_read(A_STAT, d); chk("R8 no flag while locked", d, 8'h00);
    chk("R8 irq idle while locked", {7'b0, irq_no}, 8'h01);
    check_buf("R8 buffer intact", 143);
    reg_write(A_CTRL, 8'h00);

    // R8: lock set mid-frame discards remainder
    frm_start_i = 1'b1; frm_len_i = 8'd10;
    @(negedge clk_i);
    frm_start_i = 1'b0;
    for (int i = 0; i < 3; i++) begin
      frm_valid_i = 1'b1; frm_data_i = pay(10, i); @(negedge clk_i);
    end
    frm_valid_i = 1'b0;
    reg_write(A_CTRL, 8'h04);
    for (int i = 3; i < 10; i++) begin
      frm_valid_i = 1'b1; frm_data_i = pay(10, i); @(negedge clk_i);
    end
    frm_valid_i = 1'b0;
    frm_end_i = 1'b1; frm_lqi_i = 8'h11; frm_rssi_i = 8'h22;
    @(negedge clk_i);
    frm_end_i = 1'b0;
    @(negedge clk_i);
    reg_write(A_CTRL, 8'h00);
    shadow[0] = 8'd10;
    for (int i = 0; i < 3; i++) shadow[1 + i] = pay(10, i);
    reg_read(A_STAT, d); chk("R8 mid-frame no rx flag", d, 8'h00);
    check_buf("R8 mid-frame remainder dropped", 13);

    // R9: bus writes to buffer range ignored
    reg_write(8'h05, 8'hEE);
    reg_read(8'h05, d); chk("R9 buffer write ignored", d, shadow[5]);
    reg_write(8'h00, 8'hEE);
    reg_read(8'h00, d); chk("R9 length write ignored", d, shadow[0]);

    finish_run();
  end
endmodule